// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block arbitrates between one non-maskable request and a parameterized set of level-sensitive maskable requests (external lines plus peripheral sources). Every maskable source owns a 4-bit priority field. The fields live in a small bank of 16-bit registers that software writes and reads through a synchronous port. Each cycle the block picks the pending maskable source with the highest priority. It then compares that priority with the 4-bit mask that the CPU currently holds.

While the CPU signals that it can take an interrupt, the block raises a one-cycle accept pulse. The pulse carries a vector index and the mask value the CPU should load next. The vector index selects the service-routine entry in the CPU's vector table. The non-maskable request sits at a fixed level above all programmable levels and is never blocked by the mask. When it is accepted, the new mask is 4'hF. Requests are levels: a source stays pending until it drops its own line.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every priority field reads 0, `ack_o` is low and `reg_rdata_o` is 0.
- R2: Register n holds the priorities of sources 4n to 4n+3, and source 4n+j uses bits [4j+3:4j]. Read data appears on `reg_rdata_o` one cycle after the address is presented. An address with no sources behind it reads 0, and a write to it changes no field.
- R3: While `cpu_ready_i` is high, the non-maskable request is accepted whatever the mask is, with vector 0 and new mask 4'hF.
- R4: The non-maskable request wins over every pending maskable source.
- R5: A maskable source is accepted only when its priority is strictly greater than `cpu_mask_i`. A priority equal to the mask is not accepted.
- R6: For an accepted maskable source with index k, `ack_vec_o` is k+1 and `ack_mask_o` is that source's priority.
- R7: Among pending maskable sources, the one with the highest priority is accepted.
- R8: When several pending sources share the highest priority, the one with the lowest index is accepted.
- R9: A source programmed to priority 0 is never accepted.
- R10: An accept happens only in the cycle after `cpu_ready_i` was high, and `ack_o` is never high in two consecutive cycles. A request that is still pending is accepted again after a one-cycle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request (level) |
| req_i | input | NUM_SRC | Maskable requests (level), bit k is source k |
| cpu_mask_i | input | 4 | Current CPU interrupt mask |
| cpu_ready_i | input | 1 | CPU can take an interrupt |
| reg_we_i | input | 1 | Priority register write strobe |
| reg_addr_i | input | ADDR_W | Priority register address |
| reg_wdata_i | input | REG_W | Priority register write data |
| reg_rdata_o | output | REG_W | Priority register read data, registered |
| ack_o | output | 1 | One-cycle accept pulse |
| ack_vec_o | output | $clog2(NUM_SRC+1) | Vector index: 0 for non-maskable, k+1 for source k |
| ack_mask_o | output | 4 | Mask value the CPU loads on accept |

## Verification
The arbitration is driven with a single source whose priority equals the mask and then sits one below it, which separates a strict comparison from a non-strict one. It is also driven with two sources of different priorities placed so that index order and priority order disagree, which shows whether priority or position decides. Equal-priority pairs expose the tie order. A priority-0 source with a mask of 0 exposes any off-by-one in the enable test. The non-maskable line is raised under a full mask and together with the strongest maskable source. Holding ready high over several cycles reveals the required alternating pulse pattern.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int PRIO_W = 4;
  localparam logic [PRIO_W-1:0] NMI_LOAD_MASK = 4'hF;
endpackage

// File: rtl/prio_regs.sv
module prio_regs #(
  parameter int NUM_SRC = 8,
  parameter int REG_W   = 16,
  parameter int ADDR_W  = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [REG_W-1:0]                     wdata_i,
  output logic [REG_W-1:0]                     rdata_o,
  output logic [NUM_SRC-1:0][irq_pkg::PRIO_W-1:0] prio_o
);
  localparam int PW     = irq_pkg::PRIO_W;
  localparam int FIELDS = REG_W / PW;
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0][PW-1:0] prio_q;
  logic [REG_W-1:0]           rd_d;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
    localparam int REG_IDX = s / FIELDS;
    localparam int LSB     = (s % FIELDS) * PW;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[s] <= '0;
      else if (we_i && (int'(addr_i) == REG_IDX)) prio_q[s] <= wdata_i[LSB +: PW];
    end
  end

  always_comb begin
    rd_d = '0;
    for (int f = 0; f < FIELDS; f++) begin
      int src;
      src = int'(addr_i) * FIELDS + f;
      if (src < NUM_SRC) rd_d[f*PW +: PW] = prio_q[src[IDX_W-1:0]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end

  assign prio_o = prio_q;
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0]                      req_i,
  input  logic [NUM_SRC-1:0][irq_pkg::PRIO_W-1:0] prio_i,
  output logic [irq_pkg::PRIO_W-1:0]              win_prio_o,
  output logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)-1:0] win_idx_o
);
  localparam int PW    = irq_pkg::PRIO_W;
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // strict compare while scanning upward keeps the lowest index on ties
  always_comb begin
    win_prio_o = '0;
    win_idx_o  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && (prio_i[i] > win_prio_o)) begin
        win_prio_o = prio_i[i];
        win_idx_o  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int IDX_W = 3,
  parameter int VEC_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       nmi_i,
  input  logic [irq_pkg::PRIO_W-1:0] win_prio_i,
  input  logic [IDX_W-1:0]           win_idx_i,
  input  logic [irq_pkg::PRIO_W-1:0] cpu_mask_i,
  input  logic                       cpu_ready_i,
  output logic                       ack_o,
  output logic [VEC_W-1:0]           ack_vec_o,
  output logic [irq_pkg::PRIO_W-1:0] ack_mask_o
);
  logic beats_mask, fire;

  // priority 0 never exceeds any mask, so win_prio 0 means nothing pending
  assign beats_mask = win_prio_i > cpu_mask_i;
  assign fire       = cpu_ready_i && !ack_o && (nmi_i || beats_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o      <= 1'b0;
      ack_vec_o  <= '0;
      ack_mask_o <= '0;
    end else begin
      ack_o <= fire;
      if (fire) begin
        if (nmi_i) begin
          ack_vec_o  <= '0;
          ack_mask_o <= irq_pkg::NMI_LOAD_MASK;
        end else begin
          ack_vec_o  <= VEC_W'(win_idx_i) + VEC_W'(1);
          ack_mask_o <= win_prio_i;
        end
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC = 8,
  parameter int REG_W   = 16,
  parameter int ADDR_W  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         nmi_i,
  input  logic [NUM_SRC-1:0]           req_i,
  input  logic [3:0]                   cpu_mask_i,
  input  logic                         cpu_ready_i,
  input  logic                         reg_we_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [REG_W-1:0]             reg_wdata_i,
  output logic [REG_W-1:0]             reg_rdata_o,
  output logic                         ack_o,
  output logic [$clog2(NUM_SRC+1)-1:0] ack_vec_o,
  output logic [3:0]                   ack_mask_o
);
  localparam int PW    = irq_pkg::PRIO_W;
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int VEC_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0][PW-1:0] prio;
  logic [PW-1:0]              win_prio;
  logic [IDX_W-1:0]           win_idx;

  prio_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .prio_o  (prio)
  );

  prio_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .req_i      (req_i),
    .prio_i     (prio),
    .win_prio_o (win_prio),
    .win_idx_o  (win_idx)
  );

  irq_accept #(.IDX_W(IDX_W), .VEC_W(VEC_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nmi_i       (nmi_i),
    .win_prio_i  (win_prio),
    .win_idx_i   (win_idx),
    .cpu_mask_i  (cpu_mask_i),
    .cpu_ready_i (cpu_ready_i),
    .ack_o       (ack_o),
    .ack_vec_o   (ack_vec_o),
    .ack_mask_o  (ack_mask_o)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_SRC = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         nmi_i,
  input logic [NUM_SRC-1:0]           req_i,
  input logic [3:0]                   cpu_mask_i,
  input logic                         cpu_ready_i,
  input logic                         ack_o,
  input logic [$clog2(NUM_SRC+1)-1:0] ack_vec_o,
  input logic [3:0]                   ack_mask_o
);
  // R10
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R10
  ready_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(cpu_ready_i));

  // R3
  nmi_load_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ack_vec_o == '0) |-> (ack_mask_o == 4'hF));

  // R5
  strict_above_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ack_vec_o != '0) |-> (ack_mask_o > $past(cpu_mask_i)));

  // R4
  nmi_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && cpu_ready_i && !ack_o) |=> (ack_o && ack_vec_o == '0));

  // R9
  idle_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_i && req_i == '0) |=> !ack_o);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .nmi_i       (nmi_i),
  .req_i       (req_i),
  .cpu_mask_i  (cpu_mask_i),
  .cpu_ready_i (cpu_ready_i),
  .ack_o       (ack_o),
  .ack_vec_o   (ack_vec_o),
  .ack_mask_o  (ack_mask_o)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int NUM_SRC = 8;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 2;
  localparam int VEC_W   = $clog2(NUM_SRC + 1);

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               nmi_i = 1'b0;
  logic [NUM_SRC-1:0] req_i = '0;
  logic [3:0]         cpu_mask_i = '0;
  logic               cpu_ready_i = 1'b0;
  logic               reg_we_i = 1'b0;
  logic [ADDR_W-1:0]  reg_addr_i = '0;
  logic [REG_W-1:0]   reg_wdata_i = '0;
  logic [REG_W-1:0]   reg_rdata_o;
  logic               ack_o;
  logic [VEC_W-1:0]   ack_vec_o;
  logic [3:0]         ack_mask_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  prio_irq_ctrl #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .ADDR_W(ADDR_W)) uut (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input int a, input int d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = ADDR_W'(a); reg_wdata_i = REG_W'(d);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic read_reg(input string req, input int a, input int exp);
    @(negedge clk_i);
    reg_addr_i = ADDR_W'(a);
    @(negedge clk_i);
    chk(req, int'(reg_rdata_o), exp);
  endtask

  // one accept attempt: expect ack (or none) with vector and mask
  task automatic try_irq(input string req, input int rq, input bit nmi, input int mask,
                         input bit exp_ack, input int exp_vec, input int exp_mask);
    @(negedge clk_i);
    req_i = NUM_SRC'(rq); nmi_i = nmi; cpu_mask_i = 4'(mask); cpu_ready_i = 1'b1;
    @(negedge clk_i);
    chk({req, " ack"}, int'(ack_o), int'(exp_ack));
    if (exp_ack) begin
      chk({req, " vec"}, int'(ack_vec_o), exp_vec);
      chk({req, " mask"}, int'(ack_mask_o), exp_mask);
    end
    cpu_ready_i = 1'b0; req_i = '0; nmi_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 ack", int'(ack_o), 0);
    chk("R1 rdata", int'(reg_rdata_o), 0);
    read_reg("R1 reg1", 1, 0);
  endtask

  task automatic t_regs();
    write_reg(0, 16'h4321);
    write_reg(1, 16'h8765);
    read_reg("R2 reg0", 0, 16'h4321);
    read_reg("R2 reg1", 1, 16'h8765);
    write_reg(2, 16'hFFFF);
    read_reg("R2 unmapped", 2, 0);
    read_reg("R2 reg0 kept", 0, 16'h4321);
  endtask

  task automatic t_mask();
    try_irq("R5 equal", 32'h08, 0, 4, 0, 0, 0);
    try_irq("R5 above", 32'h08, 0, 3, 1, 4, 4);
    try_irq("R6 src5", 32'h20, 0, 0, 1, 6, 6);
  endtask

  task automatic t_highest();
    try_irq("R7 pick", 32'h42, 0, 0, 1, 7, 7);
    try_irq("R7 pick2", 32'h81, 0, 2, 1, 8, 8);
  endtask

  task automatic t_tie();
    write_reg(0, 16'h5555);
    try_irq("R8 tie", 32'h06, 0, 0, 1, 2, 5);
    try_irq("R8 tie4", 32'h0C, 0, 4, 1, 3, 5);
  endtask

  task automatic t_zero();
    write_reg(1, 16'h8760);
    try_irq("R9 zero", 32'h10, 0, 0, 0, 0, 0);
  endtask

  task automatic t_nmi();
    try_irq("R3 nmi", 32'h00, 1, 15, 1, 0, 15);
    try_irq("R4 nmi win", 32'h80, 1, 0, 1, 0, 15);
  endtask

  task automatic t_ready();
    @(negedge clk_i);
    req_i = 8'h80; cpu_mask_i = 4'h0; cpu_ready_i = 1'b0;
    @(negedge clk_i);
    chk("R10 not ready", int'(ack_o), 0);
    @(negedge clk_i);
    chk("R10 not ready2", int'(ack_o), 0);
    cpu_ready_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R10 pulse", int'(ack_o), (i % 2 == 0) ? 1 : 0);
    end
    cpu_ready_i = 1'b0; req_i = '0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_mask();
    t_highest();
    t_tie();
    t_zero();
    t_nmi();
    t_ready();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule